// File: doc/BRIEF.md
# Programmable LCD Display Timing Generator

This block produces the raster timing for a TFT panel. It drives horizontal sync, vertical sync, a data-enable strobe, and the current pixel and line positions. Software writes every timing value through a simple register-write port. Each timing register holds a window: the start position sits in bits 31:16 and the end position in bits 15:0. A signal is active while start <= counter < end.

A free-running pixel counter moves once per enabled pixel clock, and a line counter moves each time the pixel counter wraps. Sync and data enable come from comparing these counters against the windows. Timing writes are held in a pending bank and copied into a working bank only at a frame boundary, so a frame is never built from a mix of old and new values.

An 8-bit serial mode spreads each active pixel over three pixel clocks. The block can be stopped in two ways. A regular disable lets the current frame finish first. The quick-disable input stops the block at once.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the block is idle. Both counters read 0, de_o is 0, hsync_o and vsync_o are 0, and pclk_inv_o is 0.
- R2: While running, h_cnt_o rises by one on each clock with pclk_en high. It returns to 0 after the value htotal-1, where htotal is bits 31:16 of the register at address 6. v_cnt_o rises by one on each such wrap and returns to 0 after vtotal-1, where vtotal is bits 15:0 of address 6.
- R3: Before polarity is applied, hsync is high while start <= h_cnt_o < end, using the window at address 2. Vsync is high while start <= v_cnt_o < end, using the window at address 3. Both are low while idle.
- R4: de_o is high only while running and while both windows hold. The horizontal window at address 4 is compared to h_cnt_o, and the vertical window at address 5 is compared to v_cnt_o.
- R5: A clock with pclk_en low leaves both counters and all outputs unchanged.
- R6: The config register at address 1 controls polarity. Bit 1 is the pixel-clock inversion and appears on pclk_inv_o. Bit 2 inverts hsync_o and bit 3 inverts vsync_o, including their idle level.
- R7: Writing the control register at address 0 with bit 3 set and bit 4 clear starts an idle block with both counters at 0. The next enabled clock advances the pixel counter. The same write to a running block is ignored.
- R8: Writing address 0 with bit 4 set while running requests a regular disable. The raster carries on to the last pixel of the current frame and then goes idle with both counters at 0.
- R9: quick_dis high at a clock edge makes the block idle and clears both counters at that edge.
- R10: Writes to addresses 1 to 6 take effect at the next frame wrap while running, and at once while idle.
- R11: With config bit 0 set (serial mode), every h_cnt_o value inside the horizontal active window is held for three enabled clocks. A line therefore lasts htotal + 2*w clocks, where w is the width of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pclk_en | input | 1 | Pixel-clock enable; one raster step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| quick_dis | input | 1 | Immediate stop |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| pclk_inv_o | output | 1 | Active pixel-clock inversion setting |
| h_cnt_o | output | 16 | Current pixel position |
| v_cnt_o | output | 16 | Current line position |

## Verification
The assertions assume that the active total register is nonzero and that every window lies inside its total. They also assume that quick_dis and the control writes arrive as single-cycle strobes that never meet a frame wrap in the same cycle. The bench programs one small raster (10 clocks by 7 lines) only while the block is idle. It issues every control and config write in the middle of a frame, so each stop or polarity change lands at a known count. A bench-side model of the counters, built from the requirements, gives the expected value at every sampled cycle.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    localparam int CW    = 16;
    localparam int DW    = 2 * CW;
    localparam int AW    = 3;
    localparam int NBANK = 6;

    localparam logic [AW-1:0] A_CTRL = 3'd0;

    // bank slots (address minus one)
    localparam int I_CFG   = 0;
    localparam int I_HSYNC = 1;
    localparam int I_VSYNC = 2;
    localparam int I_HACT  = 3;
    localparam int I_VACT  = 4;
    localparam int I_TOTAL = 5;
    localparam int NWIN    = 4;

    localparam int CTRL_EN  = 3;
    localparam int CTRL_DIS = 4;
    localparam int CFG_SER  = 0;
    localparam int CFG_PINV = 1;
    localparam int CFG_HINV = 2;
    localparam int CFG_VINV = 3;

    localparam int PH_LAST = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} tg_state_e;

    typedef struct packed {
        tg_state_e      st;
        logic [CW-1:0]  h;
        logic [CW-1:0]  v;
        logic [1:0]     ph;
    } tg_core_s;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
#(
    parameter int N = NBANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 load,
    output logic [N-1:0][DW-1:0] bank_o
);
    logic [N-1:0][DW-1:0] pend_d, pend_q, shad_d, shad_q;

    always_comb begin
        pend_d = pend_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en && wr_addr == AW'(i + 1)) pend_d[i] = wr_data;
        end
        shad_d = load ? pend_d : shad_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            shad_q <= '0;
        end else begin
            pend_q <= pend_d;
            shad_q <= shad_d;
        end
    end

    assign bank_o = shad_q;
endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window #(
    parameter int W = 16
) (
    input  logic [W-1:0]   cnt,
    input  logic [2*W-1:0] bounds,
    output logic           hit
);
    logic [W-1:0] lo, hi;
    assign lo  = bounds[2*W-1:W];
    assign hi  = bounds[W-1:0];
    assign hit = (cnt >= lo) && (cnt < hi);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pclk_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          quick_dis,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pclk_inv_o,
    output logic [CW-1:0] h_cnt_o,
    output logic [CW-1:0] v_cnt_o
);
    tg_core_s                 q, d;
    logic [NBANK-1:0][DW-1:0] bank;
    logic [NWIN-1:0]          win;
    logic [DW-1:0]            cfg;
    logic [CW-1:0]            htot, vtot;
    logic running, serial, stretch, step, adv, h_last, v_last, frame_end, load;

    assign cfg     = bank[I_CFG];
    assign htot    = bank[I_TOTAL][DW-1:CW];
    assign vtot    = bank[I_TOTAL][CW-1:0];
    assign running = (q.st != ST_IDLE);
    assign serial  = cfg[CFG_SER];

    lcd_tg_regs #(.N(NBANK)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .load   (load),
        .bank_o (bank)
    );

    // even slots compare the pixel counter, odd slots the line counter
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        lcd_tg_window #(.W(CW)) u_win (
            .cnt   ((g % 2 == 0) ? q.h : q.v),
            .bounds(bank[I_HSYNC + g]),
            .hit   (win[g])
        );
    end

    assign h_last    = ({1'b0, q.h} + 17'd1) >= {1'b0, htot};
    assign v_last    = ({1'b0, q.v} + 17'd1) >= {1'b0, vtot};
    assign stretch   = serial && win[I_HACT - I_HSYNC];
    assign step      = !stretch || (q.ph == 2'(PH_LAST));
    assign adv       = running && pclk_en;
    assign frame_end = adv && step && h_last && v_last;
    assign load      = !running || frame_end;

    always_comb begin
        d = q;
        if (adv) begin
            if (!step) begin
                d.ph = q.ph + 2'd1;
            end else begin
                d.ph = '0;
                if (h_last) begin
                    d.h = '0;
                    d.v = v_last ? '0 : q.v + CW'(1);
                end else begin
                    d.h = q.h + CW'(1);
                end
            end
        end
        if (wr_en && wr_addr == A_CTRL) begin
            if (wr_data[CTRL_DIS] && running)
                d.st = ST_DRAIN;
            else if (wr_data[CTRL_EN] && !wr_data[CTRL_DIS] && !running)
                d.st = ST_RUN;
        end
        if (q.st == ST_DRAIN && frame_end) d.st = ST_IDLE;
        if (quick_dis) begin
            d.st = ST_IDLE;
            d.h  = '0;
            d.v  = '0;
            d.ph = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, h: '0, v: '0, ph: '0};
        else        q <= d;
    end

    assign hsync_o    = (running && win[0]) ^ cfg[CFG_HINV];
    assign vsync_o    = (running && win[1]) ^ cfg[CFG_VINV];
    assign de_o       = running && win[I_HACT - I_HSYNC] && win[I_VACT - I_HSYNC];
    assign pclk_inv_o = cfg[CFG_PINV];
    assign h_cnt_o    = q.h;
    assign v_cnt_o    = q.v;
endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker
    import lcd_tg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          pclk_en,
    input logic          quick_dis,
    input logic          running,
    input logic          de_o,
    input logic [CW-1:0] h,
    input logic [CW-1:0] v,
    input logic [CW-1:0] htot
);
    p_line_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v != $past(v)) |-> (h == '0));

    p_h_below_total_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && htot != '0) |-> (h < htot));

    p_idle_no_de_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !de_o);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !pclk_en && !quick_dis) |=> ($stable(h) && $stable(v)));

    p_quick_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        quick_dis |=> (!running && h == '0 && v == '0));
endmodule

bind lcd_timing_gen lcd_tg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pclk_en  (pclk_en),
    .quick_dis(quick_dis),
    .running  (running),
    .de_o     (de_o),
    .h        (h_cnt_o),
    .v        (v_cnt_o),
    .htot     (htot)
);

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
    localparam int HT = 10, VT = 7;
    localparam int HS0 = 0, HS1 = 2, VS0 = 0, VS1 = 1;
    localparam int HA0 = 3, HA1 = 7, VA0 = 2, VA1 = 5;

    logic clk = 0, rst_n = 0, pclk_en = 0, wr_en = 0, quick_dis = 0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic hsync_o, vsync_o, de_o, pclk_inv_o;
    logic [15:0] h_cnt_o, v_cnt_o;

    int checks = 0, errors = 0;
    int exp_h = 0, exp_v = 0, exp_ph = 0;
    bit exp_run = 0, exp_drain = 0;
    logic [3:0] cfg_pend = '0, cfg_sh = '0;

    always #5 clk = ~clk;

    lcd_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .quick_dis(quick_dis),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pclk_inv_o(pclk_inv_o), .h_cnt_o(h_cnt_o), .v_cnt_o(v_cnt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // requirement-level model of one clock edge
    task automatic model_edge();
        bit was_run = exp_run, was_drain = exp_drain, fe = 0, stretch;
        stretch = cfg_sh[0] && exp_h >= HA0 && exp_h < HA1;
        if (was_run && pclk_en) begin
            if (stretch && exp_ph != 2) exp_ph++;
            else begin
                exp_ph = 0;
                if (exp_h == HT - 1) begin
                    exp_h = 0;
                    if (exp_v == VT - 1) begin exp_v = 0; fe = 1; end
                    else exp_v++;
                end else exp_h++;
            end
        end
        if (wr_en && wr_addr == 3'd1) cfg_pend = wr_data[3:0];
        if (!was_run || fe) cfg_sh = cfg_pend;
        if (wr_en && wr_addr == 3'd0) begin
            if (wr_data[4] && was_run) exp_drain = 1;
            else if (wr_data[3] && !wr_data[4] && !was_run) exp_run = 1;
        end
        if (was_drain && fe) begin exp_run = 0; exp_drain = 0; end
        if (quick_dis) begin
            exp_run = 0; exp_drain = 0; exp_h = 0; exp_v = 0; exp_ph = 0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic check_all();
        chk("R2 h_cnt", int'(h_cnt_o), exp_h);
        chk("R2 v_cnt", int'(v_cnt_o), exp_v);
        chk("R3/R6 hsync", int'(hsync_o),
            int'((exp_run && exp_h >= HS0 && exp_h < HS1) ^ cfg_sh[2]));
        chk("R3/R6 vsync", int'(vsync_o),
            int'((exp_run && exp_v >= VS0 && exp_v < VS1) ^ cfg_sh[3]));
        chk("R4 de", int'(de_o), int'(exp_run && exp_h >= HA0 && exp_h < HA1
                                      && exp_v >= VA0 && exp_v < VA1));
        chk("R6 pclk_inv", int'(pclk_inv_o), int'(cfg_sh[1]));
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] dt);
        wr_en = 1; wr_addr = a; wr_data = dt;
        tick();
        wr_en = 0;
    endtask

    task automatic t_reset();
        chk("R1 h_cnt", int'(h_cnt_o), 0);
        chk("R1 v_cnt", int'(v_cnt_o), 0);
        chk("R1 de", int'(de_o), 0);
        chk("R1 hsync", int'(hsync_o), 0);
        chk("R1 vsync", int'(vsync_o), 0);
        chk("R1 pclk_inv", int'(pclk_inv_o), 0);
    endtask

    task automatic t_program();
        pclk_en = 1;
        wr(3'd2, {16'(HS0), 16'(HS1)});
        wr(3'd3, {16'(VS0), 16'(VS1)});
        wr(3'd4, {16'(HA0), 16'(HA1)});
        wr(3'd5, {16'(VA0), 16'(VA1)});
        wr(3'd6, {16'(HT), 16'(VT)});
        chk("R10 idle no count", int'(h_cnt_o), 0);
    endtask

    task automatic t_scan();
        wr(3'd0, 32'h8);
        chk("R7 start at zero", int'(h_cnt_o), 0);
        check_all();
        for (int i = 0; i < 150; i++) begin tick(); check_all(); end
        wr(3'd0, 32'h8);
        check_all();
    endtask

    task automatic t_stall();
        int hh = int'(h_cnt_o);
        pclk_en = 0;
        for (int i = 0; i < 5; i++) begin tick(); check_all(); end
        chk("R5 stall hold", int'(h_cnt_o), hh);
        pclk_en = 1;
    endtask

    task automatic t_polarity();
        wr(3'd1, 32'hE);
        chk("R10 cfg deferred", int'(pclk_inv_o), 0);
        check_all();
        for (int i = 0; i < 80; i++) begin tick(); check_all(); end
        chk("R6 pclk_inv applied", int'(pclk_inv_o), 1);
    endtask

    task automatic t_regular_disable();
        int rem = (VT - 1 - exp_v) * HT + (HT - 1 - exp_h) + 1;
        int n = 1;
        wr(3'd0, 32'h10);
        check_all();
        while (exp_run && n < 200) begin tick(); check_all(); n++; end
        chk("R8 frame completes", n, rem);
        for (int i = 0; i < 5; i++) tick();
        chk("R8 idle h", int'(h_cnt_o), 0);
        chk("R8 idle de", int'(de_o), 0);
        chk("R8 idle hsync level", int'(hsync_o), 1);
    endtask

    task automatic t_quick();
        wr(3'd1, 32'h0);
        chk("R10 idle cfg immediate", int'(hsync_o), 0);
        wr(3'd0, 32'h8);
        for (int i = 0; i < 25; i++) begin tick(); check_all(); end
        quick_dis = 1;
        tick();
        quick_dis = 0;
        chk("R9 h cleared", int'(h_cnt_o), 0);
        chk("R9 v cleared", int'(v_cnt_o), 0);
        chk("R9 de off", int'(de_o), 0);
        for (int i = 0; i < 3; i++) tick();
        chk("R9 stays idle", int'(h_cnt_o), 0);
    endtask

    task automatic t_serial();
        int n = 0;
        wr(3'd1, 32'h1);
        wr(3'd0, 32'h8);
        while (v_cnt_o == 0 && n < 100) begin tick(); check_all(); n++; end
        chk("R11 line length", n, HT + 2 * (HA1 - HA0));
        for (int i = 0; i < 120; i++) begin tick(); check_all(); end
        quick_dis = 1;
        tick();
        quick_dis = 0;
        check_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_program();
        t_scan();
        t_stall();
        t_polarity();
        t_regular_disable();
        t_quick();
        t_serial();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule